// File: doc/BRIEF.md
# Iterative Lowest-Set-Bit Locator

This block finds the lowest-indexed set bit of a wide vector. It does not build one large combinational priority encoder. It stores the vector and narrows a search window over several clock cycles. A start pulse loads the vector into a window register. One cycle then checks the whole stored vector for zero. After that, each cycle OR-reduces the lower half of the current window. When the lower half holds a one, the block keeps that half. When it does not, the block moves the window up by half its size. When the window is down to one bit, the block registers the position as a 1-based index and raises a one-cycle completion strobe.

The vector width is a parameter. It must be a power of two, at least 2, and may be up to 512 bits. For W bits, a non-zero search takes log2(W) narrowing steps plus the zero-check cycle. An all-zero vector finishes straight after the zero check and reports 0. The result stays in its register until the next search finishes or a reset arrives. A busy flag shows when a search is running. A start pulse that arrives while busy is ignored.

Top module: `first_one_seeker`

## Requirements
- R1: After a search, `result_o` equals one plus the index of the lowest set bit of the vector captured at start (bit 0 set gives 1; bit W-1 alone gives W).
- R2: With several bits set, only the lowest-indexed one counts (bits 3 and 7 set gives 4; all ones gives 1).
- R3: An all-zero captured vector gives `result_o` = 0, with `done_o` high in the cycle after the clock edge that sampled the start.
- R4: For a non-zero vector, `done_o` goes high exactly log2(W)+1 cycles after the edge that sampled `start_i` (5 cycles at W=16, 10 at W=512).
- R5: `done_o` is high for exactly one cycle per search.
- R6: A `start_i` sampled while `busy_o` is high is ignored. The running search completes once, with the result of the vector captured first.
- R7: Between completions, `result_o` holds its value whatever `vec_i` and `start_i` do.
- R8: A synchronous active-high `rst` clears `result_o`, `done_o` and `busy_o`, even in the middle of a search, and no completion follows from the aborted search.
- R9: `busy_o` is high from the cycle after the start edge up to the completion, and is low in the cycle where `done_o` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Starts a search when sampled high while idle |
| vec_i | input | WIDTH | Vector to search, captured on the start edge |
| result_o | output | $clog2(WIDTH)+1 | 1-based index of the lowest set bit, 0 if none |
| done_o | output | 1 | One-cycle strobe: `result_o` is newly valid |
| busy_o | output | 1 | A search is in progress |

## Verification
The bench builds two copies of the block, one with W=16 and one with W=512.

The 16-bit copy is small enough to check every single-bit position. It also takes the multi-bit patterns, the all-zero case, a start pulse in the middle of a search, a reset in the middle of a search and the hold interval.

The 512-bit copy runs the full nine-step window descent. It shows the completion within the cycle budget for the largest width, and a top-bit hit that exercises the widest base arithmetic.

// File: rtl/fof_pkg.sv
package fof_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ZCHK  = 2'd1,
    ST_NARROW = 2'd2
  } fof_state_e;
endpackage

// File: rtl/fof_slice_or.sv
// OR-reduction of the lower half of the current window.
// The window is kept right-aligned in its register, so the lower half is
// always bits [half-1:0]. One reduction is built per possible half size,
// and the current level picks one of them.
module fof_slice_or #(
  parameter int WIDTH = 512,
  localparam int LOG   = $clog2(WIDTH),
  localparam int LVL_W = $clog2(LOG + 1)
) (
  input  logic [WIDTH-1:0] win_i,
  input  logic [LVL_W-1:0] level_i,
  output logic             low_any_o
);
  logic [LOG-1:0] part_any;

  for (genvar j = 0; j < LOG; j++) begin : g_part
    assign part_any[j] = |win_i[(1 << j) - 1:0];
  end

  // level L means a window of 2**L bits, whose lower half is 2**(L-1) bits
  always_comb begin
    low_any_o = 1'b0;
    for (int k = 0; k < LOG; k++) begin
      if (level_i == LVL_W'(k + 1)) low_any_o = part_any[k];
    end
  end
endmodule

// File: rtl/fof_window.sv
// Window register: loads the vector on start and, on each narrowing
// step, either keeps its contents (lower half kept) or shifts the upper
// half down into place.
module fof_window #(
  parameter int WIDTH = 512,
  localparam int LOG   = $clog2(WIDTH),
  localparam int LVL_W = $clog2(LOG + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic [WIDTH-1:0] vec_i,
  input  logic             step_i,
  input  logic             keep_low_i,
  input  logic [LVL_W-1:0] level_i,
  output logic [WIDTH-1:0] win_o,
  output logic             all_zero_o
);
  logic [WIDTH-1:0] win_q;
  logic [WIDTH-1:0] shifted [LOG];
  logic [WIDTH-1:0] up_sel;
  logic             armed_q;

  for (genvar j = 0; j < LOG; j++) begin : g_shift
    assign shifted[j] = win_q >> (1 << j);
  end

  always_comb begin
    up_sel = win_q;
    for (int k = 0; k < LOG; k++) begin
      if (level_i == LVL_W'(k + 1)) up_sel = shifted[k];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      win_q <= '0;
    end else if (load_i) begin
      win_q <= vec_i;
    end else if (step_i && !keep_low_i) begin
      win_q <= up_sel;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) armed_q <= 1'b0;
    else     armed_q <= 1'b1;
  end

  assign win_o      = win_q;
  assign all_zero_o = ~|win_q;

  // R6: with no load and no step the window must not move
  p_window_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (armed_q && !load_i && !step_i) |=> $stable(win_q));
endmodule

// File: rtl/fof_sequencer.sv
// Controls the search: idle, then the zero check, then log2(W) narrowing
// steps. It tracks the window base and writes the registered result and
// the done strobe.
module fof_sequencer
  import fof_pkg::*;
#(
  parameter int WIDTH = 512,
  localparam int LOG   = $clog2(WIDTH),
  localparam int LVL_W = $clog2(LOG + 1),
  localparam int RES_W = LOG + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic             all_zero_i,
  input  logic             low_any_i,
  output logic             load_o,
  output logic             step_o,
  output logic [LVL_W-1:0] level_o,
  output logic             busy_o,
  output logic             done_o,
  output logic [RES_W-1:0] result_o
);
  fof_state_e       state_q;
  logic [LVL_W-1:0] level_q;
  logic [LOG-1:0]   base_q;
  logic [LOG-1:0]   half;
  logic [LOG-1:0]   base_next;
  logic             done_q;
  logic [RES_W-1:0] result_q;

  assign half      = LOG'(1) << (level_q - LVL_W'(1));
  assign base_next = low_any_i ? base_q : base_q + half;
  assign load_o    = (state_q == ST_IDLE) && start_i;
  assign step_o    = (state_q == ST_NARROW);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      level_q  <= '0;
      base_q   <= '0;
      done_q   <= 1'b0;
      result_q <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) state_q <= ST_ZCHK;
        end
        ST_ZCHK: begin
          if (all_zero_i) begin
            result_q <= '0;
            done_q   <= 1'b1;
            state_q  <= ST_IDLE;
          end else begin
            level_q <= LVL_W'(LOG);
            base_q  <= '0;
            state_q <= ST_NARROW;
          end
        end
        ST_NARROW: begin
          if (level_q == LVL_W'(1)) begin
            result_q <= RES_W'(base_next) + RES_W'(1);
            done_q   <= 1'b1;
            state_q  <= ST_IDLE;
          end else begin
            level_q <= level_q - LVL_W'(1);
            base_q  <= base_next;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign level_o  = level_q;
  assign busy_o   = (state_q != ST_IDLE);
  assign done_o   = done_q;
  assign result_o = result_q;

  // R5: completion strobe lasts one cycle
  p_done_pulse_r5: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q);
  // R4: narrowing only runs at a legal level
  p_level_range_r4: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_NARROW) |-> (level_q != '0 && level_q <= LVL_W'(LOG)));
  // R9: no busy flag in the completion cycle
  p_idle_at_done_r9: assert property (@(posedge clk) disable iff (rst)
    done_q |-> !busy_o);
endmodule

// File: rtl/first_one_seeker.sv
module first_one_seeker #(
  parameter int WIDTH = 512,
  localparam int LOG   = $clog2(WIDTH),
  localparam int LVL_W = $clog2(LOG + 1),
  localparam int RES_W = LOG + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [WIDTH-1:0] vec_i,
  output logic [RES_W-1:0] result_o,
  output logic             done_o,
  output logic             busy_o
);
  logic             load;
  logic             step;
  logic [LVL_W-1:0] level;
  logic [WIDTH-1:0] win;
  logic             all_zero;
  logic             low_any;

  fof_window #(.WIDTH(WIDTH)) u_window (
    .clk        (clk),
    .rst        (rst),
    .load_i     (load),
    .vec_i      (vec_i),
    .step_i     (step),
    .keep_low_i (low_any),
    .level_i    (level),
    .win_o      (win),
    .all_zero_o (all_zero)
  );

  fof_slice_or #(.WIDTH(WIDTH)) u_slice_or (
    .win_i     (win),
    .level_i   (level),
    .low_any_o (low_any)
  );

  fof_sequencer #(.WIDTH(WIDTH)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .start_i    (start_i),
    .all_zero_i (all_zero),
    .low_any_i  (low_any),
    .load_o     (load),
    .step_o     (step),
    .level_o    (level),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .result_o   (result_o)
  );

  // R1: each narrowing step works on a window that still holds a one
  p_step_nonempty_r1: assert property (@(posedge clk) disable iff (rst)
    step |-> !all_zero);
  // R3: a zero check that finds nothing ends the search at once with 0
  p_zero_finish_r3: assert property (@(posedge clk) disable iff (rst)
    (busy_o && all_zero) |=> (done_o && result_o == '0));
endmodule

// File: tb/first_one_seeker_bench.sv
`timescale 1ns/1ps
module first_one_seeker_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic        st_n = 1'b0, st_w = 1'b0;
  logic [15:0] v_n = '0;
  logic [511:0] v_w = '0;
  logic [4:0]  res_n;
  logic [9:0]  res_w;
  logic        done_n, busy_n, done_w, busy_w;

  int checks = 0;
  int errors = 0;

  first_one_seeker #(.WIDTH(16)) u_first_one_seeker (
    .clk(clk), .rst(rst), .start_i(st_n), .vec_i(v_n),
    .result_o(res_n), .done_o(done_n), .busy_o(busy_n));

  first_one_seeker #(.WIDTH(512)) u_first_one_seeker_wide (
    .clk(clk), .rst(rst), .start_i(st_w), .vec_i(v_w),
    .result_o(res_w), .done_o(done_w), .busy_o(busy_w));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int ref_first(input logic [511:0] v, input int w);
    for (int i = 0; i < w; i++) if (v[i]) return i + 1;
    return 0;
  endfunction

  function automatic int get_res(input bit wide);
    return wide ? int'(res_w) : int'(res_n);
  endfunction

  function automatic bit get_done(input bit wide);
    return wide ? done_w : done_n;
  endfunction

  function automatic bit get_busy(input bit wide);
    return wide ? busy_w : busy_n;
  endfunction

  task automatic set_start(input bit wide, input bit s, input logic [511:0] v);
    if (wide) begin st_w = s; v_w = v; end
    else begin st_n = s; v_n = v[15:0]; end
  endtask

  // one search; poke: second start while busy (R6)
  task automatic search(input bit wide, input logic [511:0] vec, input string req, input bit poke);
    int w, lat, expv, n;
    bit got;
    w    = wide ? 512 : 16;
    expv = ref_first(vec, w);
    lat  = (expv == 0) ? 2 : (wide ? 11 : 6);
    got  = 0;
    n    = 0;
    @(negedge clk);
    set_start(wide, 1'b1, vec);
    while (n < 40) begin
      @(negedge clk);
      n++;
      if (n == 1) begin
        set_start(wide, 1'b0, vec);
        chk(get_busy(wide) == 1'b1, "R9 busy after start", get_busy(wide), 1);
      end
      if (poke && n == 2) set_start(wide, 1'b1, 512'h1);
      if (poke && n == 3) set_start(wide, 1'b0, 512'h1);
      if (get_done(wide)) begin got = 1; break; end
    end
    chk(got, {req, " done seen"}, got, 1);
    chk(n == lat, (expv == 0) ? "R3 latency" : "R4 latency", n, lat);
    chk(get_res(wide) == expv, req, get_res(wide), expv);
    chk(get_busy(wide) == 1'b0, "R9 idle at done", get_busy(wide), 0);
    @(negedge clk);
    chk(get_done(wide) == 1'b0, "R5 single pulse", get_done(wide), 0);
    if (poke) begin
      repeat (8) begin
        @(negedge clk);
        chk(get_done(wide) == 1'b0, "R6 no second completion", get_done(wide), 0);
      end
    end
  endtask

  task automatic t_reset_state();
    chk(res_n == 0, "R8 reset result", res_n, 0);
    chk(done_n == 0, "R8 reset done", done_n, 0);
    chk(busy_n == 0, "R8 reset busy", busy_n, 0);
    chk(res_w == 0 && done_w == 0 && busy_w == 0, "R8 reset wide", res_w, 0);
  endtask

  task automatic t_single_bits();
    for (int i = 0; i < 16; i++) search(1'b0, 512'h1 << i, "R1 single bit", 1'b0);
  endtask

  task automatic t_multi_bits();
    logic [15:0] lf;
    search(1'b0, 512'h0088, "R2 bits 3 and 7", 1'b0);
    search(1'b0, 512'hFFFF, "R2 all ones", 1'b0);
    search(1'b0, 512'hC000, "R2 top two", 1'b0);
    lf = 16'hB400;
    for (int k = 0; k < 6; k++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      search(1'b0, {496'b0, lf}, "R2 mixed pattern", 1'b0);
    end
  endtask

  task automatic t_zero();
    search(1'b0, 512'h0, "R3 all zero", 1'b0);
  endtask

  task automatic t_busy_start();
    search(1'b0, 512'h0A40, "R6 start while busy", 1'b1);
  endtask

  task automatic t_hold();
    int held;
    search(1'b0, 512'h0100, "R1 before hold", 1'b0);
    held = res_n;
    v_n = 16'h0001;
    repeat (5) begin
      @(negedge clk);
      chk(res_n == held && done_n == 0, "R7 result held", res_n, held);
    end
  endtask

  task automatic t_reset_mid();
    @(negedge clk);
    st_n = 1'b1; v_n = 16'h2000;
    @(negedge clk);
    st_n = 1'b0;
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk(res_n == 0 && busy_n == 0 && done_n == 0, "R8 mid-search reset", res_n, 0);
    repeat (8) begin
      @(negedge clk);
      chk(done_n == 0, "R8 no completion after abort", done_n, 0);
    end
    search(1'b0, 512'h0030, "R8 recovers", 1'b0);
  endtask

  task automatic t_wide();
    search(1'b1, 512'h1 << 300, "R1 wide bit 300", 1'b0);
    search(1'b1, 512'h1 << 511, "R1 wide top bit", 1'b0);
    search(1'b1, (512'h1 << 511) | (512'h1 << 256) | (512'h1 << 77), "R2 wide multi", 1'b0);
    search(1'b1, 512'h0, "R3 wide zero", 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset_state();
    t_single_bits();
    t_multi_bits();
    t_zero();
    t_busy_start();
    t_hold();
    t_reset_mid();
    t_wide();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule